// File: doc/BRIEF.md
# Polled EEPROM Write Controller

This block drives the address, data and control strobes of an asynchronous byte-wide EEPROM, acting as bus master. Each request supplies a start address, up to `MAX_BURST` data bytes packed into one word, and a length field. The block loads those bytes into the memory as a page burst. Every setup, pulse and gap time is derived from the clock period and rounded up to whole cycles.

After the last byte is loaded, the block does not wait out the worst-case programming time. It repeatedly reads the last address it wrote. It compares bit 7 of each read with bit 7 of the last byte written. The memory returns the inverse of that bit while it is still programming. A match ends the request cleanly. If `POLL_MAX` reads pass without a match, the request ends with a timeout flag.

The upstream side is a valid/ready handshake. Ready stays low from acceptance until completion is reported.

Top module: `eeprom_poll_writer`

## Requirements
- R1: Out of reset and whenever idle, `req_ready` is 1, `done` and `timeout` are 0, `mem_drive` is 0, and `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1.
- R2: For byte i of a request (0 ≤ i ≤ `req_len`), the data driven on `mem_wdata` is `req_data[8*i+7:8*i]`. Address and data stay stable for the whole time `mem_we_n` is low.
- R3: Within a burst, byte i is written at an address whose low `PAGE_BITS` bits equal the start address's low bits plus i, modulo 2^`PAGE_BITS`. The upper address bits equal those of the start address.
- R4: `mem_we_n` stays low for ceil(max(150 ns, 100 ns)/`CLK_NS`) cycles. Between two loads of one burst, it stays high for at least ceil(50 ns/`CLK_NS`) cycles.
- R5: `mem_oe_n` is high for at least ceil(10 ns/`CLK_NS`) cycles before `mem_we_n` falls. `mem_drive` is never 1 while `mem_oe_n` is 0. `mem_we_n` and `mem_oe_n` are never low together.
- R6: After the last load, a poll read holds `mem_oe_n` low for ceil(100 ns/`CLK_NS`) cycles with the last written address on `mem_addr`. If the sampled `mem_rdata[7]` equals bit 7 of the last byte written, `done` pulses with `timeout` at 0.
- R7: A poll read whose bit 7 differs is followed by `mem_oe_n` high for ceil(50 ns/`CLK_NS`) cycles and then another poll read.
- R8: If `POLL_MAX` consecutive poll reads all mismatch, `done` pulses with `timeout` at 1 after the last of them. `timeout` is never 1 without `done`.
- R9: `req_ready` falls in the cycle after a request is accepted and stays low until the cycle in which `done` pulses. `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | AW | Start address of the burst |
| req_data | input | 8*MAX_BURST | Bytes of the burst, byte 0 in the low bits |
| req_len | input | LW | Number of bytes minus one |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Completion was by poll limit, not by match |
| mem_addr | output | AW | Memory address bus |
| mem_wdata | output | 8 | Write data toward the pads |
| mem_drive | output | 1 | Pad output enable for write data |
| mem_rdata | input | 8 | Read data from the pads |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The hardest cases to reach are the two neighbours of the poll limit: a match on exactly the last allowed read, and a mismatch on it. The bench memory model counts down a per-request number of busy reads, during which it returns the inverted bit 7. Requests are run with that count set to `POLL_MAX`-1, `POLL_MAX` and well beyond, using a small `POLL_MAX`. A burst that starts two bytes below the page boundary exercises the address wrap.

// File: rtl/eeprom_poll_writer.sv
module eeprom_poll_writer #(
  parameter int AW        = 17,
  parameter int PAGE_BITS = 6,
  parameter int MAX_BURST = 4,
  parameter int CLK_NS    = 10,
  parameter int T_WP_NS   = 150,
  parameter int T_WPH_NS  = 50,
  parameter int T_DS_NS   = 100,
  parameter int T_OES_NS  = 10,
  parameter int T_OE_NS   = 100,
  parameter int POLL_MAX  = 1024,
  localparam int LW = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [AW-1:0]          req_addr,
  input  logic [8*MAX_BURST-1:0] req_data,
  input  logic [LW-1:0]          req_len,
  output logic                   done,
  output logic                   timeout,
  output logic [AW-1:0]          mem_addr,
  output logic [7:0]             mem_wdata,
  output logic                   mem_drive,
  input  logic [7:0]             mem_rdata,
  output logic                   mem_ce_n,
  output logic                   mem_oe_n,
  output logic                   mem_we_n
);

  function automatic int to_cyc(int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int WP_NS   = (T_WP_NS > T_DS_NS) ? T_WP_NS : T_DS_NS;
  localparam int WP_CYC  = to_cyc(WP_NS);
  localparam int WPH_CYC = to_cyc(T_WPH_NS);
  localparam int OES_CYC = to_cyc(T_OES_NS);
  localparam int OE_CYC  = to_cyc(T_OE_NS);
  localparam int TW      = 16;
  localparam int PW      = $clog2(POLL_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_OES, S_WLO, S_WHI, S_RD, S_GAP} st_t;

  st_t                    st;
  logic [TW-1:0]          tmr;
  logic [AW-1:0]          base;
  logic [8*MAX_BURST-1:0] dbuf;
  logic [LW-1:0]          len, idx;
  logic [PW-1:0]          pcnt;
  logic [PAGE_BITS-1:0]   off;
  logic [7:0]             cur;
  logic                   unused_rd;

  assign cur       = dbuf[int'(idx)*8 +: 8];
  assign off       = base[PAGE_BITS-1:0] + PAGE_BITS'(idx);
  assign mem_addr  = {base[AW-1:PAGE_BITS], off};
  assign mem_wdata = cur;
  assign req_ready = (st == S_IDLE);
  assign mem_ce_n  = (st == S_IDLE);
  assign mem_we_n  = (st != S_WLO);
  assign mem_oe_n  = (st != S_RD);
  assign mem_drive = (st == S_OES) || (st == S_WLO) || (st == S_WHI);
  assign unused_rd = ^mem_rdata[6:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tmr     <= '0;
      base    <= '0;
      dbuf    <= '0;
      len     <= '0;
      idx     <= '0;
      pcnt    <= '0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done    <= 1'b0;
      timeout <= 1'b0;
      if (st != S_IDLE && tmr != '0) begin
        tmr <= tmr - 1'b1;
      end else begin
        case (st)
          S_IDLE: if (req_valid) begin
            base <= req_addr;
            dbuf <= req_data;
            len  <= req_len;
            idx  <= '0;
            pcnt <= '0;
            tmr  <= TW'(OES_CYC - 1);
            st   <= S_OES;
          end
          S_OES: begin
            tmr <= TW'(WP_CYC - 1);
            st  <= S_WLO;
          end
          S_WLO: begin
            tmr <= TW'(WPH_CYC - 1);
            st  <= S_WHI;
          end
          S_WHI: begin
            if (idx == len) begin
              tmr <= TW'(OE_CYC - 1);
              st  <= S_RD;
            end else begin
              idx <= idx + 1'b1;
              tmr <= TW'(WP_CYC - 1);
              st  <= S_WLO;
            end
          end
          S_RD: begin
            if (mem_rdata[7] == cur[7]) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else if (pcnt == PW'(POLL_MAX - 1)) begin
              done    <= 1'b1;
              timeout <= 1'b1;
              st      <= S_IDLE;
            end else begin
              pcnt <= pcnt + 1'b1;
              tmr  <= TW'(WPH_CYC - 1);
              st   <= S_GAP;
            end
          end
          S_GAP: begin
            tmr <= TW'(OE_CYC - 1);
            st  <= S_RD;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/eeprom_poll_writer_sva.sv
module eeprom_poll_writer_sva #(
  parameter int AW      = 17,
  parameter int WP_CYC  = 15,
  parameter int WPH_CYC = 5,
  parameter int OES_CYC = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          timeout,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata,
  input logic          mem_drive,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n
);
  logic [15:0] lo_run, hi_run, oe_run;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= '0;
      oe_run <= '0;
      seen   <= 1'b0;
    end else begin
      lo_run <= mem_we_n ? '0 : lo_run + 1'b1;
      hi_run <= (!mem_we_n || mem_ce_n) ? '0 : hi_run + 1'b1;
      oe_run <= !mem_oe_n ? '0 : ((oe_run == 16'hFFFF) ? oe_run : oe_run + 1'b1);
      seen   <= mem_ce_n ? 1'b0 : (!mem_we_n ? 1'b1 : seen);
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_drive));
  p_bus_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_wdata)));
  p_we_low_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && lo_run != 0) |-> (lo_run >= 16'(WP_CYC)));
  p_we_high_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_we_n) && seen) |-> (hi_run >= 16'(WPH_CYC)));
  p_oe_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (oe_run >= 16'(OES_CYC)));
  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_drive && !mem_oe_n));
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
  p_timeout_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> done);
  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind eeprom_poll_writer eeprom_poll_writer_sva #(
  .AW(AW), .WP_CYC(WP_CYC), .WPH_CYC(WPH_CYC), .OES_CYC(OES_CYC)
) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .timeout(timeout), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_drive(mem_drive), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
);

// File: tb/eeprom_poll_writer_bench.sv
module eeprom_poll_writer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int PB = 6;
  localparam int MB = 4;
  localparam int PMAX = 8;
  localparam int EXP_WP = (150 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int EXP_WPH = (50 + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int EXP_OE = (100 + CLK_PERIOD - 1) / CLK_PERIOD;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [8*MB-1:0] req_data = '0;
  logic [1:0] req_len = '0;
  logic done, timeout, mem_drive, mem_ce_n, mem_oe_n, mem_we_n;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  int checks = 0, errors = 0;
  logic [AW-1:0] exp_addr_q[$];
  logic [7:0]    exp_data_q[$];
  logic          exp_err_q[$];
  int            exp_reads_q[$];
  int            busy_cfg = 0;
  logic [AW-1:0] exp_last = '0;

  int busy_left = 0, reads_seen = 0, lo_cnt = 0, hi_cnt = 0, oe_cnt = 0;
  logic [7:0] last_wr = '0;
  logic we_q = 1, oe_q = 1, first_we = 1;

  assign mem_rdata = (busy_left > 0) ? {~last_wr[7], last_wr[6:0]} : last_wr;

  eeprom_poll_writer #(.AW(AW), .PAGE_BITS(PB), .MAX_BURST(MB), .CLK_NS(CLK_PERIOD),
                       .POLL_MAX(PMAX)) u_eeprom_poll_writer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_len(req_len),
    .done(done), .timeout(timeout), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_drive(mem_drive), .mem_rdata(mem_rdata), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (we_q && !mem_we_n) begin
      lo_cnt <= 1;
      check(mem_oe_n && mem_drive, "R5 oe high and driving at write", {mem_oe_n, mem_drive}, 3);
      if (!first_we) check(hi_cnt >= EXP_WPH, "R4 high gap", hi_cnt, EXP_WPH);
      first_we <= 0;
    end else if (!mem_we_n) lo_cnt <= lo_cnt + 1;
    if (!we_q && mem_we_n) begin
      check(lo_cnt == EXP_WP, "R4 low width", lo_cnt, EXP_WP);
      if (exp_addr_q.size() == 0) check(0, "R2 unexpected write", int'(mem_addr), 0);
      else begin
        logic [AW-1:0] ea;
        logic [7:0] ed;
        ea = exp_addr_q.pop_front();
        ed = exp_data_q.pop_front();
        check(mem_addr == ea, "R3 write address", int'(mem_addr), int'(ea));
        check(mem_wdata == ed, "R2 write data", int'(mem_wdata), int'(ed));
      end
      last_wr <= mem_wdata;
      busy_left <= busy_cfg;
      hi_cnt <= 1;
    end else if (mem_we_n && !mem_ce_n) hi_cnt <= hi_cnt + 1;
    if (oe_q && !mem_oe_n) begin
      reads_seen <= reads_seen + 1;
      oe_cnt <= 1;
      check(mem_addr == exp_last, "R6 poll address", int'(mem_addr), int'(exp_last));
    end else if (!mem_oe_n) oe_cnt <= oe_cnt + 1;
    if (!oe_q && mem_oe_n) begin
      check(oe_cnt == EXP_OE, "R6 read width", oe_cnt, EXP_OE);
      if (busy_left > 0) busy_left <= busy_left - 1;
    end
    if (done) begin
      logic ee;
      int er;
      ee = exp_err_q.pop_front();
      er = exp_reads_q.pop_front();
      check(timeout == ee, ee ? "R8 timeout flag" : "R6 clean finish", int'(timeout), int'(ee));
      check(reads_seen == er, "R7 poll read count", reads_seen, er);
      check(exp_addr_q.size() == 0, "R2 all bytes written", exp_addr_q.size(), 0);
      check(req_ready, "R9 ready back at done", int'(req_ready), 1);
      reads_seen <= 0;
      first_we <= 1;
    end
    we_q <= mem_we_n;
    oe_q <= mem_oe_n;
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [8*MB-1:0] d, input int n, input int busy);
    logic [PB-1:0] lo;
    for (int i = 0; i < n; i++) begin
      lo = a[PB-1:0] + PB'(i);
      exp_addr_q.push_back({a[AW-1:PB], lo});
      exp_data_q.push_back(d[8*i +: 8]);
    end
    lo = a[PB-1:0] + PB'(n-1);
    exp_last = {a[AW-1:PB], lo};
    exp_err_q.push_back(busy >= PMAX);
    exp_reads_q.push_back(busy >= PMAX ? PMAX : busy + 1);
    busy_cfg = busy;
    @(negedge clk);
    check(req_ready, "R9 ready before request", int'(req_ready), 1);
    req_valid = 1; req_addr = a; req_data = d; req_len = 2'(n-1);
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R9 ready low after accept", int'(req_ready), 0);
    while (!done) begin
      if (req_ready) check(0, "R9 ready during busy", 1, 0);
      @(negedge clk);
    end
    @(negedge clk);
    check(!done, "R9 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !done && !timeout, "R1 reset handshake", {req_ready, done, timeout}, 4);
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_drive, "R1 reset strobes",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_drive}, 14);
    rst_n = 1;
    repeat (2) @(negedge clk);
    do_write(17'h00123, 32'h000000A5, 1, 0);
    do_write(17'h01000, 32'h0000003C, 1, 3);
    do_write(17'h10040, 32'h8844C211, 4, 2);
    do_write(17'h0ABFE, 32'h00F00D7E, 3, 1);
    do_write(17'h00200, 32'h00000081, 1, PMAX - 1);
    do_write(17'h00300, 32'h00000042, 1, PMAX);
    do_write(17'h1FFFF, 32'h0000C0DE, 2, 20);
    do_write(17'h00055, 32'h000000AA, 1, 0);
    repeat (3) @(negedge clk);
    check(req_ready && mem_ce_n && mem_oe_n && mem_we_n, "R1 idle after traffic",
          {req_ready, mem_ce_n, mem_oe_n, mem_we_n}, 15);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule